// File: doc/BRIEF.md
# Shared-Period Dual PWM Timer Group

This block is a small timer group built around one master channel and two slave channels. The master counter sets a common PWM period. Each slave channel counts from the start of every master period and drives one PWM pin. The pin stays at its active level until the slave count reaches that slave's duty value. Both pins are therefore edge-aligned to the same period start. The master also pulses an interrupt line for one cycle each time a period begins.

Software reaches the group through a single-cycle write port. A unit-enable bit gates everything else. A prescaler setting produces two divided count clocks, and each channel selects one of them. The master's data register holds the period and each slave's data register holds its duty. Each output has a combination-mode bit, a polarity bit, an enable bit and a preset level. While an output is not driven by running timer operation, its pin shows the preset level. Period and duty changes written during operation are double-buffered and only take effect at a period boundary.

Register map (write port, `wr_data` is CW bits, CW at least 8): address 0 bit 0 is the unit enable. Address 1 holds clock-A exponent in bits [3:0] and clock-B exponent in bits [7:4]; a clock with exponent k ticks once every 2^k cycles. Addresses 2, 3 and 4 are the master, slave 0 and slave 1 configuration; bit 0 selects clock B when 1 and clock A when 0. Address 5 is the period value P, and addresses 6 and 7 are the duty values of slave 0 and slave 1. Address 8 is output control, with combination mode in bits [1:0], polarity in bits [3:2] and output enable in bits [7:6]; bit 0 of each field belongs to output 0. Address 9 writes the preset levels, bit 0 for output 0 and bit 1 for output 1. Address 10 is the trigger register: bit 1 stops the group and otherwise bit 0 starts it.

Top module: `pwm_group`

## Requirements
- R1: While the unit enable (address 0 bit 0) is 0, writes to every other address are ignored, nothing counts and `period_irq` stays 0.
- R2: After reset both pins and `period_irq` are 0 and the unit is disabled.
- R3: With the unit enabled and the group stopped, a write to address 9 sets `pwm_out` to the written bits on the next cycle.
- R4: After a start trigger, `period_irq` pulses for one cycle two cycles after the trigger write. It then pulses once every P+1 ticks of the master's count clock.
- R5: With combination mode 1, enable 1 and polarity 0, an output is high for exactly D ticks of its count clock, starting in the same cycle as the `period_irq` pulse, and low for the rest of the period.
- R6: A duty of 0 keeps the output inactive for the whole period. A duty of P+1 or more keeps it active for the whole period.
- R7: Polarity bit 1 inverts the active level, so the output is low for D ticks and then high.
- R8: An output whose combination-mode bit or enable bit is 0 holds its preset level while the group runs.
- R9: Period or duty values written during operation leave the current period unchanged and apply from the next period start.
- R10: A stop trigger freezes the counters, holds both pins at their current level and suppresses `period_irq`. A later start begins a fresh period.
- R11: Each channel counts on the prescaled clock picked by its configuration bit. With exponent 1 the period lasts 2(P+1) cycles and the high time lasts 2D cycles.
- R12: A preset-level write is ignored for an output that the running timer is driving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Write data |
| pwm_out | output | 2 | Slave PWM pins, bit 0 for slave 0 |
| period_irq | output | 1 | One-cycle pulse at every period start |

## Verification
The bench measures each period from the interrupt pulse and counts high cycles on each pin. An off-by-one in the duty comparator would show as D-1 or D+1. A period counter that wraps at P instead of P+1 would move the next pulse. The duty extremes 0 and P+1 (and above) are tested separately, because a comparator that matches at zero or wraps past the period would give a short glitch or a missing active phase. Writes made in the middle of a period, to the period, the duty and the preset level, check that a design without double buffering, or one that lets software override a driven pin, changes the current period's waveform. A stop in the middle of the active phase, and a run on a halved clock, show whether a pin drops when it should hold and whether a channel ignores its clock select.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Register addresses of the write port
    typedef logic [3:0] addr_t;

    localparam addr_t ADR_UNIT      = 4'd0;
    localparam addr_t ADR_PRESC     = 4'd1;
    localparam addr_t ADR_CFG_BASE  = 4'd2;   // master, slave 0, slave 1
    localparam addr_t ADR_PERIOD    = 4'd5;
    localparam addr_t ADR_DUTY_BASE = 4'd6;   // slave 0, slave 1
    localparam addr_t ADR_OUTCTL    = 4'd8;
    localparam addr_t ADR_LEVEL     = 4'd9;
    localparam addr_t ADR_TRIG      = 4'd10;

    // Structure of the group
    localparam int NUM_SLV = 2;
    localparam int NUM_CH  = NUM_SLV + 1;
    localparam int NUM_CLK = 2;

    // Output control field positions
    localparam int OC_COMBO_LSB = 0;
    localparam int OC_POL_LSB   = 2;
    localparam int OC_OE_LSB    = 6;

    // Trigger bits
    localparam int TRG_START = 0;
    localparam int TRG_STOP  = 1;

    typedef struct packed {
        logic [NUM_SLV-1:0] oe;
        logic [NUM_SLV-1:0] pol;
        logic [NUM_SLV-1:0] combo;
    } out_ctl_t;

    typedef enum logic [1:0] {
        MS_STOP = 2'd0,
        MS_KICK = 2'd1,
        MS_RUN  = 2'd2
    } mstate_e;

    function automatic addr_t cfg_addr(input int ch);
        return addr_t'(int'(ADR_CFG_BASE) + ch);
    endfunction

    function automatic addr_t duty_addr(input int slv);
        return addr_t'(int'(ADR_DUTY_BASE) + slv);
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  addr_t                          wr_addr,
    input  logic [CW-1:0]                  wr_data,
    output logic                           unit_on,
    output logic [NUM_CLK-1:0][PW-1:0]     clk_exp,
    output logic [NUM_CH-1:0]              clk_sel,
    output logic [CW-1:0]                  period,
    output logic [NUM_SLV-1:0][CW-1:0]     duty,
    output out_ctl_t                       octl,
    output logic [NUM_SLV-1:0]             lvl_wr,
    output logic [NUM_SLV-1:0]             lvl_val,
    output logic                           start_p,
    output logic                           stop_p
);

    logic acc;
    assign acc = wr_en && unit_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_on <= 1'b0;
            clk_exp <= '0;
            clk_sel <= '0;
            period  <= '0;
            duty    <= '0;
            octl    <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_UNIT) begin
                unit_on <= wr_data[0];
            end
            if (acc) begin
                if (wr_addr == ADR_PRESC) begin
                    for (int k = 0; k < NUM_CLK; k++) begin
                        clk_exp[k] <= wr_data[k*PW +: PW];
                    end
                end
                for (int c = 0; c < NUM_CH; c++) begin
                    if (wr_addr == cfg_addr(c)) begin
                        clk_sel[c] <= wr_data[0];
                    end
                end
                if (wr_addr == ADR_PERIOD) begin
                    period <= wr_data;
                end
                for (int s = 0; s < NUM_SLV; s++) begin
                    if (wr_addr == duty_addr(s)) begin
                        duty[s] <= wr_data;
                    end
                end
                if (wr_addr == ADR_OUTCTL) begin
                    octl.combo <= wr_data[OC_COMBO_LSB +: NUM_SLV];
                    octl.pol   <= wr_data[OC_POL_LSB   +: NUM_SLV];
                    octl.oe    <= wr_data[OC_OE_LSB    +: NUM_SLV];
                end
            end
        end
    end

    // Strobes: trigger and preset level act once, in the write cycle
    assign start_p = acc && (wr_addr == ADR_TRIG) && wr_data[TRG_START];
    assign stop_p  = acc && (wr_addr == ADR_TRIG) && wr_data[TRG_STOP];
    assign lvl_wr  = {NUM_SLV{acc && (wr_addr == ADR_LEVEL)}};
    assign lvl_val = wr_data[NUM_SLV-1:0];

    // R1: configuration stays frozen while the unit is disabled
    p_locked_off_r1: assert property (@(posedge clk) disable iff (rst)
        !unit_on |=> ($stable(period) && $stable(duty) && $stable(octl)
                      && $stable(clk_sel) && $stable(clk_exp)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       unit_on,
    input  logic [NUM_CLK-1:0][PW-1:0] clk_exp,
    output logic [NUM_CLK-1:0]         tick
);

    localparam int DW = (1 << PW) - 1;

    logic [DW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (unit_on) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_CLK; k++) begin : g_div
        logic [DW-1:0] mask;

        always_comb begin
            for (int j = 0; j < DW; j++) begin
                mask[j] = (j < int'(clk_exp[k]));
            end
        end

        assign tick[k] = unit_on && ((pcnt & mask) == mask);

        // R11: a divided clock never ticks in two adjacent cycles
        p_tick_spaced_r11: assert property (@(posedge clk) disable iff (rst)
            (tick[k] && clk_exp[k] != '0 && $stable(clk_exp[k]))
            |=> (!tick[k] || $changed(clk_exp[k])));
    end

endmodule

// File: rtl/pwm_master.sv
module pwm_master
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unit_on,
    input  logic          start_p,
    input  logic          stop_p,
    input  logic          tick,
    input  logic [CW-1:0] period,
    output logic          running,
    output logic          sot,
    output logic          irq
);

    mstate_e       st;
    logic [CW-1:0] mcnt;
    logic [CW-1:0] per_act;

    assign running = (st != MS_STOP);
    assign sot     = unit_on && ((st == MS_KICK) ||
                                 (st == MS_RUN && tick && mcnt == per_act));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= MS_STOP;
            mcnt    <= '0;
            per_act <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= sot;
            if (unit_on) begin
                if (sot) begin
                    mcnt    <= '0;
                    per_act <= period;
                    st      <= MS_RUN;
                end else if (st == MS_RUN && tick) begin
                    mcnt <= mcnt + 1'b1;
                end
                if (stop_p) begin
                    st <= MS_STOP;
                end else if (start_p) begin
                    st <= MS_KICK;
                end
            end
        end
    end

    // R4: first period start follows a start trigger by two cycles
    p_irq_after_start_r4: assert property (@(posedge clk) disable iff (rst)
        (unit_on && start_p && !stop_p) ##1 (unit_on && !stop_p && !start_p) |=> irq);

    // R4: the master count never passes the latched period
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        (st == MS_RUN) |-> (mcnt <= per_act));

    // R10: a stopped group raises no interrupt
    p_quiet_stopped_r10: assert property (@(posedge clk) disable iff (rst)
        !running |=> !irq);

endmodule

// File: rtl/pwm_slave.sv
module pwm_slave #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          unit_on,
    input  logic          running,
    input  logic          sot,
    input  logic          tick,
    input  logic [CW-1:0] duty,
    input  logic          combo,
    input  logic          pol,
    input  logic          oe,
    input  logic          lvl_wr,
    input  logic          lvl_val,
    output logic          pin
);

    logic [CW-1:0] scnt;
    logic [CW-1:0] duty_act;
    logic [CW:0]   nxt;
    logic          drive;
    logic          act;

    assign drive = running && combo && oe;
    assign act   = !pol;
    assign nxt   = {1'b0, scnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            scnt     <= '0;
            duty_act <= '0;
            pin      <= 1'b0;
        end else if (unit_on) begin
            if (sot) begin
                scnt     <= '0;
                duty_act <= duty;
                if (drive) begin
                    pin <= (duty != '0) ? act : !act;
                end
            end else if (running && tick) begin
                if (scnt != '1) begin
                    scnt <= scnt + 1'b1;
                end
                if (drive && nxt == {1'b0, duty_act}) begin
                    pin <= !act;
                end
            end
            if (lvl_wr && !drive) begin
                pin <= lvl_val;
            end
        end
    end

    // R8: an undriven output only moves on a preset write
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!drive && !lvl_wr) |=> $stable(pin));

    // R12: preset write has no effect on a driven output
    p_preset_blocked_r12: assert property (@(posedge clk) disable iff (rst)
        (drive && lvl_wr && !sot && !tick) |=> $stable(pin));

    // R5: a nonzero duty starts the period at the active level
    p_rise_at_start_r5: assert property (@(posedge clk) disable iff (rst)
        (sot && drive && duty != '0) |=> (pin != $past(pol)));

    // R6: a zero duty starts the period at the inactive level
    p_zero_duty_r6: assert property (@(posedge clk) disable iff (rst)
        (sot && drive && duty == '0) |=> (pin == $past(pol)));

endmodule

// File: rtl/pwm_group.sv
module pwm_group
    import pwm_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [CW-1:0]      wr_data,
    output logic [NUM_SLV-1:0] pwm_out,
    output logic               period_irq
);

    logic                           unit_on;
    logic [NUM_CLK-1:0][PW-1:0]     clk_exp;
    logic [NUM_CH-1:0]              clk_sel;
    logic [CW-1:0]                  period;
    logic [NUM_SLV-1:0][CW-1:0]     duty;
    out_ctl_t                       octl;
    logic [NUM_SLV-1:0]             lvl_wr;
    logic [NUM_SLV-1:0]             lvl_val;
    logic                           start_p;
    logic                           stop_p;
    logic [NUM_CLK-1:0]             ticks;
    logic                           running;
    logic                           sot;

    pwm_regs #(.CW(CW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .unit_on (unit_on),
        .clk_exp (clk_exp),
        .clk_sel (clk_sel),
        .period  (period),
        .duty    (duty),
        .octl    (octl),
        .lvl_wr  (lvl_wr),
        .lvl_val (lvl_val),
        .start_p (start_p),
        .stop_p  (stop_p)
    );

    pwm_prescaler #(.PW(PW)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .unit_on (unit_on),
        .clk_exp (clk_exp),
        .tick    (ticks)
    );

    pwm_master #(.CW(CW)) u_mst (
        .clk     (clk),
        .rst     (rst),
        .unit_on (unit_on),
        .start_p (start_p),
        .stop_p  (stop_p),
        .tick    (ticks[clk_sel[0]]),
        .period  (period),
        .running (running),
        .sot     (sot),
        .irq     (period_irq)
    );

    for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
        pwm_slave #(.CW(CW)) u_slv (
            .clk     (clk),
            .rst     (rst),
            .unit_on (unit_on),
            .running (running),
            .sot     (sot),
            .tick    (ticks[clk_sel[s+1]]),
            .duty    (duty[s]),
            .combo   (octl.combo[s]),
            .pol     (octl.pol[s]),
            .oe      (octl.oe[s]),
            .lvl_wr  (lvl_wr[s]),
            .lvl_val (lvl_val[s]),
            .pin     (pwm_out[s])
        );
    end

endmodule

// File: tb/sim_pwm_group.sv
`timescale 1ns/1ps
module sim_pwm_group;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pwm_out;
    logic        period_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_group u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pwm_out    (pwm_out),
        .period_irq (period_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_irq();
        while (!period_irq) @(negedge clk);
    endtask

    // Window of len samples starting at an interrupt pulse; optional write at sample 1
    task automatic measure(input int len, input int wa, input int wd,
                           output int h0, output int h1, output int ni);
        h0 = 0; h1 = 0; ni = 0;
        wait_irq();
        for (int i = 0; i < len; i++) begin
            h0 += int'(pwm_out[0]);
            h1 += int'(pwm_out[1]);
            ni += int'(period_irq);
            if (i == 1 && wa >= 0) begin
                wr_en = 1'b1; wr_addr = wa[3:0]; wr_data = wd[15:0];
            end
            if (i == 2) wr_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic setup(input int p, input int d0, input int d1, input int combo,
                         input int pol, input int oe, input int lvl);
        wr(10, 2);
        wr(5, p);
        wr(6, d0);
        wr(7, d1);
        wr(8, combo | (pol << 2) | (oe << 6));
        wr(9, lvl);
        wr(10, 1);
    endtask

    task automatic run_check(input string tag, input int len, input int e0, input int e1);
        int h0, h1, ni;
        measure(len, -1, 0, h0, h1, ni);
        chk({tag, " out0 high"}, h0, e0);
        chk({tag, " out1 high"}, h1, e1);
        chk({tag, " irq in period"}, ni, 1);
        chk({tag, " next start"}, int'(period_irq), 1);
    endtask

    task automatic t_reset();
        chk("R2 pins after reset", int'(pwm_out), 0);
        chk("R2 irq after reset", int'(period_irq), 0);
    endtask

    task automatic t_unit_off();
        int ni = 0;
        wr(9, 3);
        @(negedge clk);
        chk("R1 preset ignored while off", int'(pwm_out), 0);
        wr(10, 1);
        for (int i = 0; i < 20; i++) begin
            ni += int'(period_irq);
            @(negedge clk);
        end
        chk("R1 no irq while off", ni, 0);
    endtask

    task automatic t_preset();
        wr(0, 1);
        wr(9, 1);
        chk("R3 preset 01", int'(pwm_out), 1);
        wr(9, 2);
        chk("R3 preset 10", int'(pwm_out), 2);
    endtask

    task automatic t_basic();
        int first = 0;
        wr(10, 2);
        wr(5, 9); wr(6, 3); wr(7, 7);
        wr(8, 3 | (3 << 6));
        wr(9, 0);
        wr(10, 1);   // start; pulse expected two cycles after this write
        if (period_irq) first = 1;
        @(negedge clk);
        chk("R4 irq one cycle after start sample", int'(period_irq), 1);
        @(negedge clk);
        chk("R4 irq pulse is one cycle", int'(period_irq), first);
        run_check("R4 R5 P9 D3 D7", 10, 3, 7);
        run_check("R5 repeat period", 10, 3, 7);
    endtask

    task automatic t_extremes();
        setup(9, 0, 10, 3, 0, 3, 0);
        run_check("R6 duty zero and P+1", 10, 0, 10);
        setup(9, 1, 15, 3, 0, 3, 0);
        run_check("R6 duty one and above P+1", 10, 1, 10);
    endtask

    task automatic t_polarity();
        setup(9, 3, 7, 3, 1, 3, 0);
        run_check("R7 inverted out0", 10, 7, 7);
    endtask

    task automatic t_gating();
        setup(9, 3, 7, 1, 0, 2, 2);
        run_check("R8 out0 disabled, out1 not combined", 10, 0, 10);
    endtask

    task automatic t_update();
        int h0, h1, ni;
        setup(9, 3, 7, 3, 0, 3, 0);
        measure(10, 6, 7, h0, h1, ni);
        chk("R9 duty write keeps current period", h0, 3);
        chk("R9 period irq count", ni, 1);
        chk("R9 next start unchanged", int'(period_irq), 1);
        run_check("R9 new duty applied", 10, 7, 7);
        measure(10, 5, 5, h0, h1, ni);
        chk("R9 period write keeps current length", int'(period_irq), 1);
        chk("R9 period write one irq", ni, 1);
        run_check("R9 new period applied", 6, 6, 6);
    endtask

    task automatic t_preset_blocked();
        int h0, h1, ni;
        setup(9, 3, 7, 3, 0, 3, 0);
        measure(10, 9, 0, h0, h1, ni);
        chk("R12 preset ignored on driven out0", h0, 3);
        chk("R12 preset ignored on driven out1", h1, 7);
    endtask

    task automatic t_stop();
        int h0, h1, ni;
        setup(9, 3, 7, 3, 0, 3, 0);
        measure(10, 10, 2, h0, h1, ni);
        h0 = 0; h1 = 0; ni = 0;
        for (int i = 0; i < 30; i++) begin
            h0 += int'(pwm_out[0]);
            h1 += int'(pwm_out[1]);
            ni += int'(period_irq);
            @(negedge clk);
        end
        chk("R10 out0 held after stop", h0, 30);
        chk("R10 out1 held after stop", h1, 30);
        chk("R10 no irq after stop", ni, 0);
        wr(10, 1);
        run_check("R10 restart fresh period", 10, 3, 7);
    endtask

    task automatic t_prescale();
        wr(10, 2);
        wr(1, 16);           // clock A exponent 0, clock B exponent 1
        wr(2, 1); wr(3, 1); wr(4, 1);
        setup(4, 2, 0, 3, 0, 3, 0);
        wait_irq();
        @(negedge clk);
        run_check("R11 clock B halved", 10, 4, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unit_off();
        t_preset();
        t_basic();
        t_extremes();
        t_polarity();
        t_gating();
        t_update();
        t_preset_blocked();
        t_stop();
        t_prescale();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule